// File: doc/BRIEF.md
# 100 Mb/s Link Integrity Monitor

This block decides whether a 100 Mb/s twisted-pair link is usable. The receive signal-processing path supplies a "signal valid" indication. The monitor first requires that indication to stay high for a fixed settling time, counted in clock cycles. It then either waits for a grant from the auto-negotiation logic or, when auto-negotiation is switched off, declares the link up at once. Transmit and receive datapaths are enabled only while the link is up. Any loss of the valid indication pulls the link down on the very edge where the loss is sampled.

The state machine has three states:
- **DOWN** (code 0). The settle timer runs while valid is high.
- **READY** (code 1). Settling is complete and the monitor waits for the auto-negotiation grant.
- **UP** (code 2). The datapaths are enabled.

The transitions are:
- **DOWN→READY** when settling completes with auto-negotiation enabled.
- **DOWN→UP** when settling completes with auto-negotiation disabled.
- **READY→UP** on a grant, or when auto-negotiation is turned off.
- **any→DOWN** when valid is sampled low.

At 10 Mb/s the reported link comes straight from the 10BASE-T receiver instead of this state machine. The state machine keeps running in the background.

Top module: `lnk_integrity_mon`

## Requirements
- R1: After reset the state output is DOWN (code 0), and `link_up` and `trx_en` are low while `spd100` is 1.
- R2: With auto-negotiation enabled, the state leaves DOWN for READY (code 1) only on the rising edge at which `sig_ok` has been sampled high for SETTLE_CYC+1 consecutive edges. It never leaves earlier.
- R3: A single low sample of `sig_ok` during the settling wait restarts the count from zero, so a full new wait is needed.
- R4: In READY with auto-negotiation enabled, the state holds until `an_grant` is sampled high. On that edge it moves to UP (code 2).
- R5: An `an_grant` pulse while the state is DOWN has no effect: after settling, the state is READY, not UP.
- R6: With auto-negotiation disabled, the settled state goes from DOWN straight to UP after the same wait. Clearing `an_on` while in READY moves the state to UP on the next edge.
- R7: When `sig_ok` is sampled low in any state, the state becomes DOWN on that edge. `trx_en` falls, and `link_up` falls when `spd100` is 1, in the same cycle.
- R8: `trx_en` is high exactly when the state is UP.
- R9: When `spd100` is 1, `link_up` is high exactly in UP. When `spd100` is 0, `link_up` follows `lnk10_ok` in the same cycle, while the state machine continues to track `sig_ok`.
- R10: The state output only ever shows code 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_ok | input | 1 | Receive signal valid from the signal-processing path |
| an_on | input | 1 | Auto-negotiation enabled |
| an_grant | input | 1 | Link enable strobe from auto-negotiation |
| lnk10_ok | input | 1 | Link status from the 10BASE-T receiver |
| spd100 | input | 1 | Speed select: 1 = 100 Mb/s, 0 = 10 Mb/s |
| link_up | output | 1 | Reported link status |
| trx_en | output | 1 | Enable for transmit and receive datapaths |
| fsm_state | output | 2 | Current state: 0 DOWN, 1 READY, 2 UP |

## Verification
The hardest condition to reach from the ports is an interruption of `sig_ok` one or two cycles before the settle count completes. Without it, an off-by-one in the timer restart goes unseen. Directed sequences place single-cycle dropouts at chosen points in the wait and a grant pulse inside the DOWN state. After that, a long run seeded from `$urandom` keeps `sig_ok` mostly high, so full settling and rare dropouts both occur many times. Every cycle of that run is compared against a bench-side model of the three-state behaviour.

// File: rtl/lnkmon_pkg.sv
package lnkmon_pkg;

    typedef enum logic [1:0] {
        LM_DOWN  = 2'd0,
        LM_READY = 2'd1,
        LM_UP    = 2'd2
    } lm_state_e;

endpackage

// File: rtl/lnkmon_settle.sv
module lnkmon_settle #(
    parameter int LIMIT = 8250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_ok,
    output logic settled
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Counts cycles of continuous validity, saturating at LIM; any low sample restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!sig_ok) begin
            cnt_q <= '0;
        end else if (cnt_q != LIM) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign settled = (cnt_q == LIM);

    a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !sig_ok |=> (cnt_q == '0));

    a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);

    a_r2_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_ok && cnt_q != LIM) |=> (cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/lnkmon_fsm.sv
module lnkmon_fsm
    import lnkmon_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sig_ok,
    input  logic      an_on,
    input  logic      an_grant,
    input  logic      settled,
    output lm_state_e state_o,
    output logic      up_q,
    output logic      trx_q
);
    lm_state_e st_q;
    lm_state_e st_nxt;

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            LM_DOWN: begin
                if (settled) begin
                    st_nxt = an_on ? LM_READY : LM_UP;
                end
            end
            LM_READY: begin
                if (!an_on || an_grant) begin
                    st_nxt = LM_UP;
                end
            end
            LM_UP: begin
                st_nxt = LM_UP;
            end
            default: begin
                st_nxt = LM_DOWN;
            end
        endcase
        // Loss of validity overrides every other transition.
        if (!sig_ok) begin
            st_nxt = LM_DOWN;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= LM_DOWN;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Registered outputs, decoded from the next state so they move on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q  <= 1'b0;
            trx_q <= 1'b0;
        end else begin
            up_q  <= (st_nxt == LM_UP);
            trx_q <= (st_nxt == LM_UP);
        end
    end

    assign state_o = st_q;

    a_r2_hold_down: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LM_DOWN && !settled) |=> (st_q == LM_DOWN));

    a_r4_wait_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LM_READY && an_on && !an_grant) |=> (st_q != LM_UP));

    a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LM_READY && !an_on && sig_ok) |=> (st_q == LM_UP));

    a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !sig_ok |=> (st_q == LM_DOWN && !up_q && !trx_q));

    a_r8_enable_in_up: assert property (@(posedge clk) disable iff (!rst_n)
        trx_q |-> (st_q == LM_UP));

    a_r10_legal: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != 2'd3);

endmodule

// File: rtl/lnkmon_status_sel.sv
module lnkmon_status_sel (
    input  logic spd100,
    input  logic up100,
    input  logic lnk10_ok,
    output logic link_o
);
    always_comb begin
        link_o = spd100 ? up100 : lnk10_ok;
    end
endmodule

// File: rtl/lnk_integrity_mon.sv
module lnk_integrity_mon
    import lnkmon_pkg::*;
#(
    parameter int SETTLE_CYC = 8250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_ok,
    input  logic       an_on,
    input  logic       an_grant,
    input  logic       lnk10_ok,
    input  logic       spd100,
    output logic       link_up,
    output logic       trx_en,
    output logic [1:0] fsm_state
);
    logic      settled;
    logic      up100;
    lm_state_e st;

    lnkmon_settle #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig_ok  (sig_ok),
        .settled (settled)
    );

    lnkmon_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_ok   (sig_ok),
        .an_on    (an_on),
        .an_grant (an_grant),
        .settled  (settled),
        .state_o  (st),
        .up_q     (up100),
        .trx_q    (trx_en)
    );

    lnkmon_status_sel u_sel (
        .spd100   (spd100),
        .up100    (up100),
        .lnk10_ok (lnk10_ok),
        .link_o   (link_up)
    );

    assign fsm_state = st;

    a_r9_link_source: assert property (@(posedge clk) disable iff (!rst_n)
        (spd100 && link_up) |-> (fsm_state == 2'd2));

endmodule

// File: tb/sim_lnk_integrity_mon.sv
module sim_lnk_integrity_mon;
    localparam int CLK_PERIOD = 10;
    localparam int SET = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sig_ok = 1'b0, an_on = 1'b1, an_grant = 1'b0, lnk10_ok = 1'b0, spd100 = 1'b1;
    logic link_up, trx_en;
    logic [1:0] fsm_state;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;

    int m_cnt = 0;
    int m_st  = 0;

    lnk_integrity_mon #(.SETTLE_CYC(SET)) u0 (
        .clk(clk), .rst_n(rst_n), .sig_ok(sig_ok), .an_on(an_on),
        .an_grant(an_grant), .lnk10_ok(lnk10_ok), .spd100(spd100),
        .link_up(link_up), .trx_en(trx_en), .fsm_state(fsm_state)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Bench model of the requirements, stepped on each rising edge.
    function automatic int next_state(int st, int cnt, bit v, bit ano, bit g);
        int n = st;
        if (st == 0 && cnt == SET) n = ano ? 1 : 2;
        else if (st == 1 && (!ano || g)) n = 2;
        if (!v) n = 0;
        return n;
    endfunction

    function automatic int next_cnt(int cnt, bit v);
        if (!v) return 0;
        return (cnt == SET) ? SET : cnt + 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0;
            m_cnt = 0;
        end else begin
            m_st = next_state(m_st, m_cnt, sig_ok, an_on, an_grant);
            m_cnt = next_cnt(m_cnt, sig_ok);
        end
    end

    // Per-cycle comparison, a quarter period after the edge while inputs are still.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (model_on && rst_n) begin
            chk("R10 state", int'(fsm_state), m_st);
            chk("R8 trx_en", int'(trx_en), int'(m_st == 2));
            chk("R9 link_up", int'(link_up), spd100 ? int'(m_st == 2) : int'(lnk10_ok));
        end
    end

    task automatic cyc(input bit v, input bit ano, input bit g, input bit l10, input bit spd);
        sig_ok = v; an_on = ano; an_grant = g; lnk10_ok = l10; spd100 = spd;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 state", int'(fsm_state), 0);
        chk("R1 link", int'(link_up), 0);
        chk("R1 trx", int'(trx_en), 0);
        rst_n = 1'b1;
        model_on = 1'b1;

        // R2 / R5: settle with a grant pulse inside DOWN
        for (int i = 0; i < SET; i++) cyc(1, 1, (i == 3), 0, 1);
        chk("R2 still down", int'(fsm_state), 0);
        cyc(1, 1, 0, 0, 1);
        chk("R2 ready", int'(fsm_state), 1);
        chk("R5 not up", int'(link_up), 0);

        // R4: hold in READY, then grant
        for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 1);
        chk("R4 hold", int'(fsm_state), 1);
        cyc(1, 1, 1, 0, 1);
        chk("R4 up", int'(fsm_state), 2);
        chk("R8 trx up", int'(trx_en), 1);
        chk("R9 link up", int'(link_up), 1);

        // R7: one low sample
        cyc(0, 1, 0, 0, 1);
        chk("R7 state", int'(fsm_state), 0);
        chk("R7 link", int'(link_up), 0);
        chk("R7 trx", int'(trx_en), 0);

        // R3: dropout late in the wait restarts it
        for (int i = 0; i < SET - 1; i++) cyc(1, 1, 0, 0, 1);
        cyc(0, 1, 0, 0, 1);
        for (int i = 0; i < SET; i++) cyc(1, 1, 0, 0, 1);
        chk("R3 still down", int'(fsm_state), 0);
        cyc(1, 1, 0, 0, 1);
        chk("R3 ready", int'(fsm_state), 1);

        // R6: clear an_on in READY, then bypass from DOWN
        cyc(1, 0, 0, 0, 1);
        chk("R6 ready to up", int'(fsm_state), 2);
        cyc(0, 0, 0, 0, 1);
        for (int i = 0; i < SET; i++) cyc(1, 0, 0, 0, 1);
        chk("R6 still down", int'(fsm_state), 0);
        cyc(1, 0, 0, 0, 1);
        chk("R6 direct up", int'(fsm_state), 2);

        // R9: 10 Mb/s source
        cyc(1, 0, 0, 0, 0);
        chk("R9 ten low", int'(link_up), 0);
        cyc(1, 0, 0, 1, 0);
        chk("R9 ten high", int'(link_up), 1);
        cyc(0, 0, 0, 1, 0);
        chk("R9 fsm tracks", int'(fsm_state), 0);
        chk("R9 ten kept", int'(link_up), 1);

        // Random phase, fixed seed
        void'($urandom(32'd1234));
        begin
            bit ano = 1'b1;
            bit spd = 1'b1;
            for (int i = 0; i < 4000; i++) begin
                if ($urandom_range(99) < 2) ano = ~ano;
                if ($urandom_range(99) < 1) spd = ~spd;
                cyc($urandom_range(99) < 97, ano, $urandom_range(99) < 10,
                    $urandom_range(1) == 1, spd);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule